// File: doc/BRIEF.md
# Multi-shot ping-pong shot buffer

This block holds the samples of a multi-shot acquisition in two on-chip dual-port RAMs that take turns. Each shot is captured as a ring into one RAM. Even shots go to RAM 0 and odd shots to RAM 1. When the shot ends, its trigger-centred window is streamed to an external memory write port, and the other RAM is free to capture the next shot during that copy. The upstream acquisition sequencer frames each shot with start, trigger and end pulses. It also supplies the pre-trigger and post-trigger sample counts and a 64-bit timestamp of the trigger.

Each copied shot is laid out as a block of words in external memory. The pre-trigger samples come first, then the trigger sample, then the post-trigger samples, and last two timestamp words. Blocks follow one another with no gaps. The timestamp words reduce the usable depth of each RAM by two entries. A shot that cannot fit, or that never saw a trigger, is discarded. If a shot starts while the RAM it needs is still waiting for its copy or being copied, the block signals an overrun.

Top module: `shot_buf`

## Requirements
- R1: Accepted shots alternate between the RAMs: the first accepted shot after reset uses RAM 0, the next RAM 1, and so on. A shot may capture into one RAM while the other RAM's copy-out is in progress.
- R2: Within a shot, the sample that arrives with `shotStart` goes to RAM address 0. Each later valid sample goes to the next address, wrapping modulo `DEPTH` (2048), so older samples are overwritten.
- R3: The copy-out of a shot reads `preCnt + postCnt + 1` samples in rising address order. It begins at the trigger sample's RAM address minus `preCnt`, taken modulo `DEPTH`.
- R4: The two timestamp words follow the samples of each shot. The first word is bits 63:32 of the timestamp, zero-extended. The second word is bits 31:0, zero-extended. The timestamp used is the value on `trigStamp` in the cycle of the accepted trigger.
- R5: `wrAddr` is a word address. The first word written after reset goes to address 0. Every later word goes to the previous address plus one, so each shot occupies `preCnt + postCnt + 3` consecutive addresses.
- R6: Only the first trigger of a shot that arrives together with a valid sample is recorded. A trigger that arrives in the same cycle as `shotEnd` is still accepted.
- R7: A shot is discarded if `preCnt + postCnt + 1` exceeds `DEPTH - 2` (2046) when `shotEnd` arrives, or if it saw no trigger. A discarded shot writes nothing and does not use up a RAM turn.
- R8: `shotStart` arriving while the RAM for that shot is still pending or being copied raises `overrun` for one cycle, one cycle later. That shot is not captured.
- R9: Samples, triggers and `shotEnd` pulses outside an active shot cause no output word.
- R10: While in reset, `wrValid` and `overrun` are low.
- R11: Shots are copied out in the order they ended. The words of one shot are emitted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A sample is present on sampleData |
| sampleData | input | 64 | Sample word |
| shotStart | input | 1 | First cycle of a shot |
| trigger | input | 1 | The sample of this cycle is the trigger sample |
| shotEnd | input | 1 | Last cycle of a shot |
| preCnt | input | 12 | Number of pre-trigger samples |
| postCnt | input | 12 | Number of post-trigger samples |
| trigStamp | input | 64 | Trigger timestamp, taken in the trigger cycle |
| wrValid | output | 1 | A word is presented for external memory |
| wrAddr | output | 32 | Word destination address |
| wrData | output | 64 | Word to write |
| overrun | output | 1 | One-cycle pulse when a shot finds its RAM busy |

## Verification
The bench aims at the wrap cases.

- **RAM overwrite.** One shot is longer than the RAM, so its window straddles address 0. A block that ignored the modulo would copy stale or out-of-range words.
- **Pre-trigger count of zero.** A block that mishandled it would shift the window.
- **Trigger on the last cycle.** A trigger that coincides with `shotEnd` must still be accepted. A block that lost it would drop the shot.
- **Second trigger.** A block that let a later trigger win would move the window.

The bench also covers rejection:

- **Capacity limit.** Lengths of exactly 2046 and 2047 probe the limit. An off-by-one there would accept a shot that collides with the timestamp words, or reject a legal one.
- **Missing trigger.** A shot without a trigger must be discarded.
- **Overrun.** A shot is started while its RAM is still being copied. A block that got this wrong would corrupt the copy or skip the pulse.

Finally, after rejected shots, the bench checks that the external addresses continue without a gap and that the RAM alternation is not disturbed.

// File: rtl/shot_buf_pkg.sv
package shot_buf_pkg;

  typedef enum logic [1:0] {
    KIND_SAMP = 2'd0,
    KIND_TSHI = 2'd1,
    KIND_TSLO = 2'd2
  } wordKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      wrEn;      // write a sample into a RAM
    logic      wrBank;
    logic      trigCap;   // capture timestamp of an accepted trigger
    logic      post;      // hand a finished shot's timestamp to its RAM slot
    logic      postBank;
    logic      issue;     // a copy-out word is issued this cycle
    logic      rdBank;
    wordKind_t kind;
  } strobe_t;

endpackage

// File: rtl/shot_buf_ctrl.sv
module shot_buf_ctrl
  import shot_buf_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              shotStart,
  input  logic              trigger,
  input  logic              shotEnd,
  input  logic [CNT_W-1:0]  preCnt,
  input  logic [CNT_W-1:0]  postCnt,
  output strobe_t           strobe,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              overrun
);

  localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(DEPTH - 2);

  // capture side
  logic             bankSel;      // RAM of the next accepted shot
  logic             capActive;
  logic [PTR_W-1:0] capPtr;
  logic             trigSeen;
  logic [PTR_W-1:0] trigAddr;
  // job slots, one per RAM
  logic [1:0]       jobPend;
  logic [PTR_W-1:0] jobStart [2];
  logic [CNT_W-1:0] jobLen   [2];
  // copy side
  logic             copyActive;
  logic             copyBank;
  logic             nextBank;
  logic [CNT_W-1:0] remain;
  wordKind_t        kind;
  logic [ADDR_W-1:0] dst;

  logic             startOk, capOn, wrEn, trigHit, endHit, postOk;
  logic [PTR_W-1:0] effAddr, trigAddrNow;
  logic [CNT_W:0]   total;

  always_comb begin
    startOk     = shotStart && !jobPend[bankSel];
    capOn       = startOk || (capActive && !shotStart);
    effAddr     = shotStart ? '0 : capPtr;
    wrEn        = sampleValid && capOn;
    trigHit     = wrEn && trigger && (shotStart || !trigSeen);
    trigAddrNow = trigHit ? effAddr : trigAddr;
    total       = (CNT_W+1)'(preCnt) + (CNT_W+1)'(postCnt) + (CNT_W+1)'(1);
    endHit      = shotEnd && capActive && !shotStart;
    postOk      = endHit && (trigSeen || trigHit) && (total <= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankSel    <= 1'b0;
      capActive  <= 1'b0;
      capPtr     <= '0;
      trigSeen   <= 1'b0;
      trigAddr   <= '0;
      jobPend    <= '0;
      jobStart   <= '{default: '0};
      jobLen     <= '{default: '0};
      copyActive <= 1'b0;
      copyBank   <= 1'b0;
      nextBank   <= 1'b0;
      remain     <= '0;
      kind       <= KIND_SAMP;
      dst        <= '0;
      overrun    <= 1'b0;
    end else begin
      overrun <= shotStart && jobPend[bankSel];
      // capture
      if (shotStart) begin
        capActive <= startOk;
        trigSeen  <= 1'b0;
        capPtr    <= '0;
      end
      if (wrEn) capPtr <= effAddr + 1'b1;
      if (trigHit) begin
        trigSeen <= 1'b1;
        trigAddr <= effAddr;
      end
      if (endHit) begin
        capActive <= 1'b0;
        if (postOk) begin
          jobPend[bankSel]  <= 1'b1;
          jobStart[bankSel] <= trigAddrNow - preCnt[PTR_W-1:0];
          jobLen[bankSel]   <= total[CNT_W-1:0];
          bankSel           <= ~bankSel;
        end
      end
      // copy-out
      if (!copyActive) begin
        if (jobPend[nextBank]) begin
          copyActive <= 1'b1;
          copyBank   <= nextBank;
          rdPtr      <= jobStart[nextBank];
          remain     <= jobLen[nextBank];
          kind       <= KIND_SAMP;
        end
      end else begin
        dst <= dst + 1'b1;
        unique case (kind)
          KIND_SAMP: begin
            rdPtr  <= rdPtr + 1'b1;
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) kind <= KIND_TSHI;
          end
          KIND_TSHI: kind <= KIND_TSLO;
          default: begin
            copyActive        <= 1'b0;
            jobPend[copyBank] <= 1'b0;
            nextBank          <= ~nextBank;
          end
        endcase
      end
    end
  end

  always_comb begin
    strobe.wrEn     = wrEn;
    strobe.wrBank   = bankSel;
    strobe.trigCap  = trigHit;
    strobe.post     = postOk;
    strobe.postBank = bankSel;
    strobe.issue    = copyActive;
    strobe.rdBank   = copyBank;
    strobe.kind     = kind;
  end
  assign wrPtr   = effAddr;
  assign dstAddr = dst;

  // R1: capture never targets the RAM being read out
  p_bank_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && copyActive) |-> (bankSel != copyBank));
  // R3: a sample word is only issued while samples remain
  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (copyActive && kind == KIND_SAMP) |-> (remain != '0));
  // R8: overrun pulse is caused by a shot start
  p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(shotStart));
  // R11: a started copy runs to completion without pause
  p_copy_continuous_r11: assert property (@(posedge clk) disable iff (!rstN)
    (copyActive && kind != KIND_TSLO) |=> copyActive);

endmodule

// File: rtl/shot_buf_dp.sv
module shot_buf_dp
  import shot_buf_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 64,
  parameter int TS_W   = 64,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int HALF  = TS_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [TS_W-1:0]   trigStamp,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);

  logic [TS_W-1:0]   tsCap;
  logic [TS_W-1:0]   tsJob [2];
  logic [DATA_W-1:0] tsWordQ;
  wordKind_t         kindQ;
  logic              bankQ;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.wrBank == 1'(b)) mem[wrPtr] <= sampleData;
      if (strobe.issue && strobe.rdBank == 1'(b)) q <= mem[rdPtr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsCap    <= '0;
      tsJob    <= '{default: '0};
      tsWordQ  <= '0;
      kindQ    <= KIND_SAMP;
      bankQ    <= 1'b0;
      outValid <= 1'b0;
      outAddr  <= '0;
    end else begin
      if (strobe.trigCap) tsCap <= trigStamp;
      if (strobe.post) tsJob[strobe.postBank] <= strobe.trigCap ? trigStamp : tsCap;
      outValid <= strobe.issue;
      outAddr  <= dstAddr;
      kindQ    <= strobe.kind;
      bankQ    <= strobe.rdBank;
      tsWordQ  <= (strobe.kind == KIND_TSHI)
                  ? DATA_W'(tsJob[strobe.rdBank][TS_W-1:HALF])
                  : DATA_W'(tsJob[strobe.rdBank][HALF-1:0]);
    end
  end

  assign outData = (kindQ != KIND_SAMP) ? tsWordQ
                 : (bankQ ? g_bank[1].q : g_bank[0].q);

  // R5: consecutive output words go to consecutive addresses
  p_dst_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outAddr == $past(outAddr) + 1'b1));
  // R4: the low timestamp word directly follows the high one
  p_ts_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && kindQ == KIND_TSLO) |-> ($past(outValid) && $past(kindQ) == KIND_TSHI));

endmodule

// File: rtl/shot_buf.sv
module shot_buf
  import shot_buf_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 64,
  parameter int TS_W   = 64,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              shotStart,
  input  logic              trigger,
  input  logic              shotEnd,
  input  logic [CNT_W-1:0]  preCnt,
  input  logic [CNT_W-1:0]  postCnt,
  input  logic [TS_W-1:0]   trigStamp,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              overrun
);

  strobe_t           strobe;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [ADDR_W-1:0] dstAddr;

  shot_buf_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .shotStart(shotStart),
    .trigger(trigger), .shotEnd(shotEnd), .preCnt(preCnt), .postCnt(postCnt),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr), .dstAddr(dstAddr),
    .overrun(overrun)
  );

  shot_buf_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TS_W(TS_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .dstAddr(dstAddr), .sampleData(sampleData), .trigStamp(trigStamp),
    .outValid(wrValid), .outAddr(wrAddr), .outData(wrData)
  );

endmodule

// File: tb/sim_shot_buf.sv
module sim_shot_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;

  typedef struct packed {
    logic [11:0] pre;
    logic [11:0] post;
    logic [11:0] trig;
    logic [11:0] trig2;
    logic [11:0] len;
    logic        ok;
  } vec_t;

  localparam logic [11:0] NONE = 12'hFFF;
  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{12'd3,    12'd4,    12'd5,    NONE,  12'd10,   1'b1},  // R3 basic window
    '{12'd0,    12'd1,    12'd0,    NONE,  12'd2,    1'b1},  // R3 zero pre-trigger
    '{12'd2,    12'd0,    12'd4,    NONE,  12'd5,    1'b1},  // R6 trigger with shotEnd
    '{12'd1,    12'd2,    12'd3,    12'd5, 12'd8,    1'b1},  // R6 second trigger ignored
    '{12'd10,   12'd5,    12'd2050, NONE,  12'd2056, 1'b1},  // R2 ring wrap
    '{12'd1000, 12'd1045, 12'd1000, NONE,  12'd2046, 1'b1},  // R7 at limit
    '{12'd1000, 12'd1046, 12'd1000, NONE,  12'd2047, 1'b0},  // R7 over limit
    '{12'd2,    12'd2,    NONE,     NONE,  12'd6,    1'b0},  // R7 no trigger
    '{12'd4,    12'd3,    12'd6,    NONE,  12'd12,   1'b1}   // R1 after rejects
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic sampleValid = 1'b0, shotStart = 1'b0, trigger = 1'b0, shotEnd = 1'b0;
  logic [63:0] sampleData = '0, trigStamp = '0;
  logic [11:0] preCnt = '0, postCnt = '0;
  logic wrValid, overrun;
  logic [31:0] wrAddr;
  logic [63:0] wrData;

  shot_buf u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .shotStart(shotStart), .trigger(trigger), .shotEnd(shotEnd),
    .preCnt(preCnt), .postCnt(postCnt), .trigStamp(trigStamp),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int ovCount = 0, wordsSeen = 0, wordsExp = 0;
  int accCount = 0;
  logic [31:0] expDst = '0;
  logic [95:0] expQ [$];
  logic [63:0] mdl [2][DEPTH];
  bit monOn = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit cond, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor, samples away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      if (overrun) ovCount++;
      if (wrValid) begin
        wordsSeen++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R9 R7 unexpected write", {wrAddr, wrData}, '0);
        end else begin
          logic [95:0] e;
          e = expQ.pop_front();
          chk({wrAddr, wrData} == e, "R3 R4 R5 R11 stream word", {wrAddr, wrData}, e);
        end
      end
    end
  end

  task automatic runShot(input int id, input vec_t v, input bit expOv);
    logic bank;
    bank = accCount[0];
    preCnt  = v.pre;
    postCnt = v.post;
    for (int i = 0; i < int'(v.len); i++) begin
      @(posedge clk); #1;
      sampleValid = 1'b1;
      sampleData  = {16'hDA7A, 16'(id), 32'(i)};
      trigStamp   = {16'hC0DE, 16'(id), 32'(i) + 32'h1000_0000};
      shotStart   = (i == 0);
      trigger     = (i == int'(v.trig)) || (i == int'(v.trig2));
      shotEnd     = (i == int'(v.len) - 1);
      if (!expOv) mdl[bank][i % DEPTH] = sampleData;
    end
    @(posedge clk); #1;
    sampleValid = 1'b0; shotStart = 1'b0; trigger = 1'b0; shotEnd = 1'b0;
    if (!expOv && v.ok) begin
      int total;
      logic [63:0] ts;
      total = int'(v.pre) + int'(v.post) + 1;
      ts = {16'hC0DE, 16'(id), 32'(int'(v.trig)) + 32'h1000_0000};
      for (int j = 0; j < total; j++) begin
        expQ.push_back({expDst, mdl[bank][(int'(v.trig) - int'(v.pre) + j) % DEPTH]});
        expDst++;
      end
      expQ.push_back({expDst, 32'h0, ts[63:32]}); expDst++;
      expQ.push_back({expDst, 32'h0, ts[31:0]});  expDst++;
      wordsExp += total + 2;
      accCount++;
    end
    repeat (8) @(posedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 6000 && expQ.size() != 0; k++) @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(wrValid == 1'b0, "R10 wrValid in reset", 96'(wrValid), 96'(0));
    chk(overrun == 1'b0, "R10 overrun in reset", 96'(overrun), 96'(0));
    @(posedge clk); #1 rstN = 1'b1;
    monOn = 1'b1;

    // R9: stray pulses outside a shot
    @(posedge clk); #1 sampleValid = 1'b1; trigger = 1'b1;
    @(posedge clk); #1 shotEnd = 1'b1; trigger = 1'b0;
    @(posedge clk); #1 sampleValid = 1'b0; shotEnd = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(wordsSeen == 0, "R9 stray pulses produce no word", 96'(wordsSeen), 96'(0));

    // vector table
    for (int n = 0; n < NVEC; n++) begin
      runShot(n, VEC[n], 1'b0);
      if (!VEC[n].ok || n == 5) begin
        drain();
        chk(wordsSeen == wordsExp, "R7 word count after shot", 96'(wordsSeen), 96'(wordsExp));
      end
    end
    drain();
    chk(ovCount == 0, "R8 no overrun in spaced shots", 96'(ovCount), 96'(0));

    // R1 / R8: long copy keeps its RAM busy while the next same-RAM shot starts
    runShot(20, '{12'd0, 12'd999, 12'd0, NONE, 12'd1000, 1'b1}, 1'b0);
    runShot(21, '{12'd0, 12'd1, 12'd0, NONE, 12'd2, 1'b1}, 1'b0);
    runShot(22, '{12'd0, 12'd2, 12'd0, NONE, 12'd3, 1'b1}, 1'b1);
    drain();
    chk(ovCount == 1, "R1 R8 overrun on busy RAM", 96'(ovCount), 96'(1));
    runShot(23, '{12'd1, 12'd1, 12'd1, NONE, 12'd4, 1'b1}, 1'b0);
    drain();
    chk(expQ.size() == 0, "R11 all expected words emitted", 96'(expQ.size()), 96'(0));
    chk(wordsSeen == wordsExp, "R5 total word count", 96'(wordsSeen), 96'(wordsExp));

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule